// File: doc/BRIEF.md
# Mode-Configurable Registered Bus Transceiver

This block carries a WIDTH-bit word in two directions between an A side and a B side. The A side is split into an input bus and an output bus. The outbound path takes the A input to the B output. The inbound path takes B input data, or a looped-back copy of the outbound result, to the A output. Neither path inverts its data.

Each direction contains one storage element, and a 2-bit mode code selects how that element behaves. It can pass its input straight through, act as a rising-edge register, or act as a level-sensitive latch. The same per-direction clock serves as the register clock and as the active-high latch enable. Both the register and the latch follow their input whatever the mode is, so a change of mode only chooses which of the three values reaches the output.

The pad drivers are outside the block. Each side has a drive flag instead of a tri-state bus. Disabling a side clears its flag, but the element behind it keeps loading and holding data. The loopback control lets diagnostic software read the outbound element's output on the A side without involving the B bus.

Top module: `xcvr_reg_top`

## Requirements
- R1: Data is carried without inversion. b_out comes from a_in through the outbound element, and a_out comes from the inbound element's input through the inbound element. Both are WIDTH bits wide (default 8).
- R2: ab_mode selects the outbound element and ba_mode selects the inbound element. The codes are 2'b00 pass-through, 2'b01 register, 2'b10 latch, and 2'b11 pass-through.
- R3: In pass-through mode, the element's output equals its current input with no clock involved.
- R4: In register mode, the output equals the input value present at the most recent rising edge of that direction's clock (clk_ab outbound, clk_ba inbound). The register samples on every rising edge in every mode.
- R5: In latch mode, the output follows the input while that direction's clock is high. While the clock is low, the output holds the value present when the clock fell. The latch tracks its input in every mode.
- R6: When rst is high at a rising edge of a direction's clock, that direction's register is cleared to zero. The latches are not affected by rst.
- R7: With loopback low, the inbound element's input is b_in. With loopback high, its input is the outbound element's output, whatever ab_mode is.
- R8: a_drive equals a_oe. When a_drive is low the A output counts as high-impedance.
- R9: b_drive is high only when b_oe is 1 and b_oe_n is 0. All three other combinations give 0.
- R10: While a side's drive flag is low, its element still loads and holds data. Enabling the side afterwards presents the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset, synchronous to each direction clock, clears the registers |
| clk_ab | input | 1 | Outbound register clock and latch enable |
| clk_ba | input | 1 | Inbound register clock and latch enable |
| ab_mode | input | 2 | Outbound element mode code |
| ba_mode | input | 2 | Inbound element mode code |
| loopback | input | 1 | 1 feeds the outbound result to the inbound element |
| a_oe | input | 1 | A output enable, active high |
| b_oe | input | 1 | B output enable, active high |
| b_oe_n | input | 1 | B output enable, active low |
| a_in | input | WIDTH | A side input data |
| b_in | input | WIDTH | B side input data |
| a_out | output | WIDTH | A side output data |
| a_drive | output | 1 | A output driven when 1 |
| b_out | output | WIDTH | B side output data |
| b_drive | output | 1 | B output driven when 1 |

## Verification
The bench builds the block at the default width of 8. At this width a random byte exercises every data bit, and all four mode codes, both loopback settings and all eight enable combinations come up many times within a few hundred steps. The bench steps each clock as an ordinary level input, one change at a time. This lets a latch see its input change while its enable is high, lets the register and latch disagree after a clock falls, and lets a reset edge land in any mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_DW = 8;
    localparam int MODE_W  = 2;

    // Raw mode codes as seen on the ports
    typedef enum logic [MODE_W-1:0] {
        MODE_BUF     = 2'b00,
        MODE_FLOP    = 2'b01,
        MODE_LATCH   = 2'b10,
        MODE_ALT_BUF = 2'b11
    } mode_code_e;

    // Behaviour an element takes once the code is decoded
    typedef enum logic [1:0] {
        ELEM_PASS  = 2'd0,
        ELEM_FLOP  = 2'd1,
        ELEM_LATCH = 2'd2
    } elem_kind_e;

    typedef struct packed {
        logic a_path;
        logic b_path;
    } drive_t;

    function automatic elem_kind_e kind_of(logic [MODE_W-1:0] code);
        case (mode_code_e'(code))
            MODE_FLOP:  return ELEM_FLOP;
            MODE_LATCH: return ELEM_LATCH;
            default:    return ELEM_PASS;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_cell.sv
module xcvr_cell
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_DW
) (
    input  logic              le_clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [WIDTH-1:0]  d,
    output logic [WIDTH-1:0]  q
);

    elem_kind_e       kind;
    logic [WIDTH-1:0] flop_q;
    logic [WIDTH-1:0] latch_q;

    assign kind = kind_of(mode);

    // Register samples on every rising edge, whatever the mode
    always_ff @(posedge le_clk) begin
        if (rst) flop_q <= '0;
        else     flop_q <= d;
    end

    // Latch is transparent while the enable is high, in every mode
    always_latch begin
        if (le_clk) latch_q <= d;
    end

    always_comb begin
        case (kind)
            ELEM_FLOP:  q = flop_q;
            ELEM_LATCH: q = latch_q;
            default:    q = d;
        endcase
    end

    // R4: register mode shows the word captured at the previous edge
    p_flop_capture_r4: assert property (@(posedge le_clk) disable iff (rst)
        (kind == ELEM_FLOP && !$past(rst)) |-> q == $past(d));

    // R5: latch mode is transparent up to the falling edge
    p_latch_open_r5: assert property (@(negedge le_clk) disable iff (rst)
        (kind == ELEM_LATCH) |-> q == d);

    // R6: an edge taken under reset leaves a zero register
    p_flop_reset_r6: assert property (@(posedge le_clk)
        (!rst && $past(rst) && kind == ELEM_FLOP) |-> q == '0);

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
(
    input  logic   a_oe,
    input  logic   b_oe,
    input  logic   b_oe_n,
    output drive_t drv
);

    always_comb begin
        drv.a_path = a_oe;
        drv.b_path = b_oe & ~b_oe_n;
    end

endmodule

// File: rtl/xcvr_reg_top.sv
module xcvr_reg_top
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_DW
) (
    input  logic              rst,
    input  logic              clk_ab,
    input  logic              clk_ba,
    input  logic [MODE_W-1:0] ab_mode,
    input  logic [MODE_W-1:0] ba_mode,
    input  logic              loopback,
    input  logic              a_oe,
    input  logic              b_oe,
    input  logic              b_oe_n,
    input  logic [WIDTH-1:0]  a_in,
    input  logic [WIDTH-1:0]  b_in,
    output logic [WIDTH-1:0]  a_out,
    output logic              a_drive,
    output logic [WIDTH-1:0]  b_out,
    output logic              b_drive
);

    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_d;
    logic [WIDTH-1:0] ba_q;
    drive_t           drv;

    xcvr_cell #(.WIDTH(WIDTH)) u_out_cell (
        .le_clk (clk_ab),
        .rst    (rst),
        .mode   (ab_mode),
        .d      (a_in),
        .q      (ab_q)
    );

    // Inbound source: bus data or the outbound result for diagnostics
    assign ba_d = loopback ? ab_q : b_in;

    xcvr_cell #(.WIDTH(WIDTH)) u_in_cell (
        .le_clk (clk_ba),
        .rst    (rst),
        .mode   (ba_mode),
        .d      (ba_d),
        .q      (ba_q)
    );

    xcvr_drive u_drive (
        .a_oe   (a_oe),
        .b_oe   (b_oe),
        .b_oe_n (b_oe_n),
        .drv    (drv)
    );

    assign b_out   = ab_q;
    assign a_out   = ba_q;
    assign a_drive = drv.a_path;
    assign b_drive = drv.b_path;

    // R7: both elements transparent and looped back, so A in reaches A out
    p_loop_pass_r7: assert property (@(posedge clk_ab) disable iff (rst)
        (loopback && kind_of(ab_mode) == ELEM_PASS && kind_of(ba_mode) == ELEM_PASS)
        |-> a_out == a_in);

endmodule

// File: tb/xcvr_reg_top_bench.sv
module xcvr_reg_top_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst, clk_ab, clk_ba, loopback, a_oe, b_oe, b_oe_n;
    logic [1:0]   ab_mode, ba_mode;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_drive, b_drive;

    xcvr_reg_top #(.WIDTH(W)) u_xcvr_reg_top (
        .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba),
        .ab_mode(ab_mode), .ba_mode(ba_mode), .loopback(loopback),
        .a_oe(a_oe), .b_oe(b_oe), .b_oe_n(b_oe_n),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [W-1:0] m_ab_ff, m_ab_lat, m_ba_ff, m_ba_lat;
    logic [W-1:0] m_ab_q, m_ba_d, m_ba_q;

    function automatic logic [W-1:0] pick(logic [1:0] m, logic [W-1:0] d,
                                          logic [W-1:0] ff, logic [W-1:0] lat);
        if (m == 2'b01) return ff;
        if (m == 2'b10) return lat;
        return d;
    endfunction

    function automatic string tag_of(logic [1:0] m);
        if (m == 2'b01) return "R4";
        if (m == 2'b10) return "R5";
        return "R3";
    endfunction

    task automatic settle();
        if (clk_ab) m_ab_lat = a_in;
        m_ab_q = pick(ab_mode, a_in, m_ab_ff, m_ab_lat);
        m_ba_d = loopback ? m_ab_q : b_in;
        if (clk_ba) m_ba_lat = m_ba_d;
        m_ba_q = pick(ba_mode, m_ba_d, m_ba_ff, m_ba_lat);
    endtask

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(b_out == m_ab_q, tag_of(ab_mode), b_out, m_ab_q);
        chk(a_out == m_ba_q, loopback ? "R7" : tag_of(ba_mode), a_out, m_ba_q);
        chk(a_drive == a_oe, "R8", W'(a_drive), W'(a_oe));
        chk(b_drive == (b_oe && !b_oe_n), "R9", W'(b_drive), W'(b_oe && !b_oe_n));
    endtask

    // One input change per step: kind selects the input, v its new value
    task automatic apply(int kind, logic [W-1:0] v);
        @(posedge clk);
        settle();
        case (kind)
            0: a_in = v;
            1: b_in = v;
            2: ab_mode = v[1:0];
            3: ba_mode = v[1:0];
            4: loopback = v[0];
            5: a_oe = v[0];
            6: b_oe = v[0];
            7: b_oe_n = v[0];
            8: begin
                if (v[0] && !clk_ab) m_ab_ff = rst ? '0 : a_in;
                clk_ab = v[0];
            end
            9: begin
                if (v[0] && !clk_ba) m_ba_ff = rst ? '0 : m_ba_d;
                clk_ba = v[0];
            end
            default: rst = v[0];
        endcase
        settle();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c3a));
        rst = 1; clk_ab = 1; clk_ba = 1; loopback = 0;
        a_oe = 0; b_oe = 0; b_oe_n = 1;
        ab_mode = 2'b01; ba_mode = 2'b01;
        a_in = '0; b_in = '0;
        m_ab_ff = '0; m_ba_ff = '0; m_ab_lat = '0; m_ba_lat = '0;
        settle();
        // Reset edges on both clocks, latches loaded with zero
        apply(8, 0); apply(9, 0);
        apply(8, 1); apply(9, 1);
        apply(8, 0); apply(9, 0);
        apply(10, 0);
        chk(b_out == '0, "R6", b_out, '0);
        chk(a_out == '0, "R6", a_out, '0);
        chk(a_drive == 1'b0 && b_drive == 1'b0, "R8", W'({a_drive, b_drive}), '0);

        // R1: pass-through in both directions
        apply(2, 0); apply(3, 0);
        apply(0, 8'h5A); apply(1, 8'hC3);
        chk(b_out == 8'h5A, "R1", b_out, 8'h5A);
        chk(a_out == 8'hC3, "R1", a_out, 8'hC3);

        // R9: all four enable combinations
        for (int c = 0; c < 4; c++) begin
            apply(6, W'(c & 1)); apply(7, W'(c >> 1));
            chk(b_drive == (c == 1), "R9", W'(b_drive), W'(c == 1));
        end
        apply(5, 1);
        chk(a_drive == 1'b1, "R8", W'(a_drive), 1);

        // R2: code 11 behaves as pass-through
        apply(2, 3); apply(3, 3); apply(0, 8'h3C); apply(1, 8'h96);
        chk(b_out == 8'h3C, "R2", b_out, 8'h3C);
        chk(a_out == 8'h96, "R2", a_out, 8'h96);

        // R10: register loads while B is disabled
        apply(6, 0); apply(2, 1); apply(0, 8'h77);
        apply(8, 1); apply(8, 0); apply(0, 8'h11);
        apply(6, 1); apply(7, 0);
        chk(b_drive && b_out == 8'h77, "R10", b_out, 8'h77);

        // R7: loopback of a registered outbound value
        apply(3, 0); apply(4, 1);
        chk(a_out == 8'h77, "R7", a_out, 8'h77);

        // R6: reset clears the register but not the latch
        apply(2, 2); apply(8, 1); apply(8, 0);
        apply(10, 1); apply(0, 8'hEE); apply(8, 1); apply(8, 0); apply(10, 0);
        chk(b_out == 8'hEE, "R6", b_out, 8'hEE);
        apply(2, 1);
        chk(b_out == '0, "R6", b_out, '0);

        // Constrained random
        for (int i = 0; i < 1500; i++) begin
            int k;
            k = int'($urandom % 12);
            if (k == 11) k = 8;
            if (k == 10) apply(10, W'(($urandom % 6) == 0));
            else apply(k, W'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule